// File: doc/BRIEF.md
# ASCII Frame Check Tail Generator

This block closes an ASCII-mode serial request frame. It watches the binary message bytes of a frame, from the address byte through the last data byte, on an input stream marked by valid, first and last strobes, and keeps an 8-bit running total of them. Once the last byte has been taken, it forms the longitudinal check value and sends the frame's closing characters on a byte stream with a ready/valid handshake. The tail is the check as two uppercase hexadecimal ASCII characters, then a carriage return and a line feed.

The check value is copied into a separate output stage when the last byte arrives. This leaves the running total free for the next frame straight away. A new frame may therefore start in the cycle after a last byte, and its own last byte may come as early as the cycle in which the previous tail's final character is accepted. Converting the message body to ASCII, sending the start character and serialising onto a line are handled by other blocks.

Top module: `lrc_frame_tail`

## Requirements
- R1: The check is based on the sum, modulo 256, of every byte taken with `in_valid` high, from the byte marked `in_first` through the byte marked `in_last`.
- R2: The check value is the two's-complement negation of that 8-bit sum. For the bytes 01, 03, 04, 01, 00, 01 the sum is 0x0A and the check is 0xF6.
- R3: The check is sent as two characters, with the upper nibble first. For example, 0xF6 is sent as 'F' (0x46) followed by '6' (0x36).
- R4: Each nibble value from 0 to 9 is encoded as 0x30 to 0x39, and each value from 10 to 15 is encoded as uppercase 0x41 to 0x46.
- R5: The two check characters are followed by CR (0x0D) and then LF (0x0A). After the LF is accepted, `out_valid` goes low unless a new tail has been loaded.
- R6: `out_valid` rises, carrying the first check character, in the cycle after the clock edge that takes the last byte.
- R7: While `out_valid` is high and `out_ready` is low, the character does not change and the sequence does not advance.
- R8: A byte marked `in_first` restarts the sum, so no earlier bytes count. This covers an earlier frame that never got a last byte, and a frame that starts while the previous tail is still being sent.
- R9: A sum of zero gives a check of 0x00, which is sent as '0' '0'.
- R10: After reset, `out_valid` is low.
- R11: A frame of one byte, with `in_first` and `in_last` both set, gives a check equal to the negation of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A message byte is present this cycle |
| in_first | input | 1 | The byte is the first of a frame |
| in_last | input | 1 | The byte is the last of a frame |
| in_data | input | 8 | Binary message byte |
| out_ready | input | 1 | The downstream side accepts the character this cycle |
| out_valid | output | 1 | A tail character is being offered |
| out_data | output | 8 | Tail character in ASCII |

## Verification
The assertions check the following on every cycle:
- A stalled character stays unchanged.
- The two check characters are always legal uppercase hex digits.
- An accepted CR is always followed by LF.
- The output goes idle after the LF.
- A last byte always starts a tail in the next cycle.
- A first byte restarts the running sum.

Only the bench scenarios can show that the characters carry the right value. These scenarios cover:
- the worked example;
- a sum that wraps past 256;
- a zero sum;
- a one-byte frame;
- a frame that was abandoned without a last byte;
- a frame that overlaps the previous tail with no idle cycle.

// File: rtl/lrc_pkg.sv
// Package: shared types and helpers for the frame check tail generator.
// Assumes the check is one byte, so it is sent as two hex characters.
package lrc_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    // Position within the four-character tail
    typedef enum logic [1:0] {
        SLOT_HI = 2'd0,
        SLOT_LO = 2'd1,
        SLOT_E0 = 2'd2,
        SLOT_E1 = 2'd3
    } slot_e;

    // Turn one nibble into an uppercase ASCII hex digit
    function automatic logic [BYTE_W-1:0] nib2asc(input logic [NIB_W-1:0] nib);
        logic [BYTE_W-1:0] wide;
        wide = {{(BYTE_W-NIB_W){1'b0}}, nib};
        if (nib < NIB_W'(10))
            return 8'h30 + wide;
        else
            return 8'h37 + wide;
    endfunction

endpackage

// File: rtl/lrc_accum.sv
// Module: lrc_accum
// Keeps the modulo-256 running sum of the message bytes of one frame.
// It also gives the sum that includes the byte presented this cycle, so
// the check can be taken in the same cycle as the last byte.
// Assumes a byte marked first begins a new frame, whatever came before.
module lrc_accum
    import lrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [BYTE_W-1:0] in_data,
    output logic [BYTE_W-1:0] sum_next
);

    logic [BYTE_W-1:0] sum_q;

    // Sum including the current byte; a first byte drops the old total
    always_comb begin
        sum_next = (in_first ? '0 : sum_q) + in_data;
    end

    // Register the running sum whenever a byte is taken
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_q <= '0;
        else if (in_valid)
            sum_q <= sum_next;
    end

    AST_FIRST_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first) |=> (sum_q == $past(in_data))); // R8

endmodule

// File: rtl/lrc_emit.sv
// Module: lrc_emit
// Holds one check value and offers the four tail characters in order:
// upper hex digit, lower hex digit, then the two end characters.
// A load restarts the sequence.
// Assumes a load arrives only while idle, or together with the
// acceptance of the final end character.
module lrc_emit
    import lrc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] END0 = 8'h0D,
    parameter logic [BYTE_W-1:0] END1 = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] chk,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);

    logic              busy_q;
    slot_e             slot_q;
    logic [BYTE_W-1:0] chk_q;
    logic              fire;
    logic              at_end;

    assign out_valid = busy_q;
    assign fire      = busy_q && out_ready;
    assign at_end    = (slot_q == SLOT_E1);

    // Sequence control: a load takes priority, and each accepted character advances
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            slot_q <= SLOT_HI;
            chk_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            slot_q <= SLOT_HI;
            chk_q  <= chk;
        end else if (fire) begin
            if (at_end)
                busy_q <= 1'b0;
            slot_q <= slot_e'(slot_q + 2'd1);
        end
    end

    // Choose the character for the current slot
    always_comb begin
        case (slot_q)
            SLOT_HI: out_data = nib2asc(chk_q[BYTE_W-1:NIB_W]);
            SLOT_LO: out_data = nib2asc(chk_q[NIB_W-1:0]);
            SLOT_E0: out_data = END0;
            default: out_data = END1;
        endcase
    end

    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!busy_q || (fire && at_end))); // R8

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

    AST_HEX_CHARSET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (slot_q == SLOT_HI || slot_q == SLOT_LO)) |->
        ((out_data >= 8'h30 && out_data <= 8'h39) ||
         (out_data >= 8'h41 && out_data <= 8'h46))); // R4

    AST_CR_THEN_LF: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_data == END0) |=> (out_valid && out_data == END1)); // R5

    AST_IDLE_AFTER_LF: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_data == END1 && !load) |=> !out_valid); // R5

endmodule

// File: rtl/lrc_frame_tail.sv
// Module: lrc_frame_tail (top)
// Adds up the binary bytes of a frame. When the last byte arrives, it loads
// the negated sum into the tail stage, which sends it as two ASCII hex
// characters followed by the two end characters.
// Assumes the input stream has no backpressure and that a frame's last
// byte does not come while the previous tail is still before its final
// character.
module lrc_frame_tail
    import lrc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] END0 = 8'h0D,
    parameter logic [BYTE_W-1:0] END1 = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);

    logic [BYTE_W-1:0] sum_next;
    logic [BYTE_W-1:0] chk;
    logic              load;

    // Form the check from the sum that includes the last byte
    always_comb begin
        load = in_valid && in_last;
        chk  = '0 - sum_next;
    end

    lrc_accum u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .in_data  (in_data),
        .sum_next (sum_next)
    );

    lrc_emit #(
        .END0 (END0),
        .END1 (END1)
    ) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .chk       (chk),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    AST_LAST_STARTS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> out_valid); // R6

endmodule

// File: tb/sim_lrc_frame_tail.sv
`timescale 1ns/1ps
module sim_lrc_frame_tail;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_ready = 1'b1;
    logic       out_valid;
    logic [7:0] out_data;

    int total = 0;
    int bad   = 0;
    logic [7:0] frm [16];

    always #10 clk = ~clk;

    lrc_frame_tail u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_first  (in_first),
        .in_last   (in_last),
        .in_data   (in_data),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] v);
        if (v < 4'd10) return 8'd48 + {4'd0, v};
        else           return 8'd65 + {4'd0, v} - 8'd10;
    endfunction

    function automatic logic [7:0] lrc_of(input int n);
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < n; i++) s = s + frm[i];
        return ~s + 8'd1;
    endfunction

    // Drive n bytes of frm; close marks the last one, otherwise leave the frame open
    task automatic send(input int n, input bit close);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = (i == 0);
            in_last  = close && (i == n - 1);
            in_data  = frm[i];
        end
        if (!close) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    // Check the four tail characters, with an optional stall after character stall_k
    task automatic collect(input logic [7:0] chk, input int stall_k, input int stall_n,
                           input bit own, input string req);
        logic [7:0] exp [4];
        exp[0] = hexc(chk[7:4]);
        exp[1] = hexc(chk[3:0]);
        exp[2] = 8'h0D;
        exp[3] = 8'h0A;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (own) begin
                in_valid = 1'b0;
                in_last  = 1'b0;
                in_first = 1'b0;
            end
            check(out_valid === 1'b1 && out_data === exp[k], req,
                  {out_valid, out_data}, {1'b1, exp[k]});
            if (k == stall_k) begin
                out_ready = 1'b0;
                for (int s = 0; s < stall_n; s++) begin
                    @(negedge clk);
                    check(out_valid === 1'b1 && out_data === exp[k], "R7 stall hold",
                          {out_valid, out_data}, {1'b1, exp[k]});
                end
                out_ready = 1'b1;
            end
        end
        if (own) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R5 idle after LF", {out_valid, out_data}, 9'h000);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R10 reset", {out_valid, out_data}, 9'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R10 after release", {out_valid, out_data}, 9'h000);
    endtask

    task automatic t_example();
        frm[0] = 8'h01; frm[1] = 8'h03; frm[2] = 8'h04;
        frm[3] = 8'h01; frm[4] = 8'h00; frm[5] = 8'h01;
        check(lrc_of(6) == 8'hF6, "R2 bench model", {1'b0, lrc_of(6)}, 9'h0F6);
        send(6, 1'b1);
        collect(lrc_of(6), -1, 0, 1'b1, "R1 R2 R3 R6 example F6");
    endtask

    task automatic t_wrap();
        frm[0] = 8'hFF; frm[1] = 8'hFF; frm[2] = 8'hFF; frm[3] = 8'hC7;
        send(4, 1'b1);
        collect(lrc_of(4), -1, 0, 1'b1, "R1 modulo-256 wrap");
    endtask

    task automatic t_zero();
        frm[0] = 8'h80; frm[1] = 8'h80;
        send(2, 1'b1);
        collect(8'h00, -1, 0, 1'b1, "R9 zero sum");
    endtask

    task automatic t_single();
        frm[0] = 8'h5A;
        send(1, 1'b1);
        collect(8'hA6, -1, 0, 1'b1, "R11 single byte");
    endtask

    task automatic t_digits();
        frm[0] = 8'h11; frm[1] = 8'h34;
        send(2, 1'b1);
        collect(lrc_of(2), -1, 0, 1'b1, "R4 digit range BB");
        frm[0] = 8'h37;
        send(1, 1'b1);
        collect(lrc_of(1), -1, 0, 1'b1, "R4 digit range C9");
    endtask

    task automatic t_stall();
        frm[0] = 8'h01; frm[1] = 8'h03; frm[2] = 8'h04;
        frm[3] = 8'h01; frm[4] = 8'h00; frm[5] = 8'h01;
        send(6, 1'b1);
        collect(8'hF6, 0, 3, 1'b1, "R7 stall first char");
        frm[0] = 8'h22;
        send(1, 1'b1);
        collect(8'hDE, 2, 2, 1'b1, "R7 stall on CR");
    endtask

    task automatic t_abandon();
        frm[0] = 8'h40; frm[1] = 8'h40; frm[2] = 8'h13;
        send(3, 1'b0);
        @(negedge clk);
        check(out_valid === 1'b0, "R8 open frame no tail", {out_valid, out_data}, 9'h000);
        frm[0] = 8'h02; frm[1] = 8'h05;
        send(2, 1'b1);
        collect(8'hF9, -1, 0, 1'b1, "R8 restart after abandoned frame");
    endtask

    task automatic t_back2back();
        logic [7:0] chk_a;
        frm[0] = 8'h10; frm[1] = 8'h20;
        chk_a = lrc_of(2);
        send(2, 1'b1);
        frm[0] = 8'h01; frm[1] = 8'h02; frm[2] = 8'h03; frm[3] = 8'h04;
        fork
            send(4, 1'b1);
            collect(chk_a, -1, 0, 1'b0, "R8 first tail during next frame");
        join
        collect(lrc_of(4), -1, 0, 1'b1, "R8 back-to-back second tail");
    endtask

    initial begin
        t_reset();
        t_example();
        t_wrap();
        t_zero();
        t_single();
        t_digits();
        t_stall();
        t_abandon();
        t_back2back();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule